// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Transfer Engine

This block is one transfer channel that copies data from a source address to a destination address over a plain request/grant memory master port. Software sets up the channel with the following:
- a 32-bit source pointer and a 32-bit destination pointer, each with its own "hold" option that keeps the pointer fixed;
- a beat size of one, two or four bytes;
- a beats-per-block count;
- a blocks-per-run count.

A software start pulse arms the channel. From then on the latched mode decides how a peripheral request line paces the beats.

Each beat is one read at the current source pointer followed by one write of the same data to the current destination pointer. The channel has three pacing modes:
- **Burst:** the whole run (beats-per-block × blocks) goes through with no further requests.
- **Block:** each request edge releases exactly one block.
- **Demand:** beats flow only while the request line stays high.

When the last write is accepted, a sticky completion flag is set and a one-cycle interrupt pulse is produced.

Top module: `dma_xfer_channel`

## Requirements
- R1: After a synchronous reset, and whenever reset is asserted mid-run, `busy`, `done`, `irq` and `mem_req` are all 0.
- R2: While idle, a `sw_start` pulse latches the whole configuration. In burst mode (`cfg_mode`=1), and also for the unused code 3, the channel then moves beats-per-block × blocks beats without needing `periph_req`.
- R3: In block mode (`cfg_mode`=0), each rising edge of `periph_req` releases exactly one block of beats. Edges seen during a block are remembered for the next block. The channel then waits until the run count is used up.
- R4: In demand mode (`cfg_mode`=2), a new beat starts only while `periph_req` is 1. When the line drops, the beat in progress finishes and `mem_req` stays low until the line rises again.
- R5: After each beat, a pointer advances by 1, 2 or 4 for `cfg_size` 0, 1 or 2 (size 3 acts as 4). A pointer whose hold bit is set keeps its value.
- R6: A beats-per-block value of 0 means 16, and a blocks value of 0 means 65536.
- R7: Every beat is a read (`mem_we`=0) at the source pointer and then a write (`mem_we`=1) at the destination pointer. Address and direction stay stable while `mem_gnt` is low. Read data is taken in the grant cycle. Write data is the read data in the low `cfg_size` byte lanes, with all other bits 0.
- R8: The grant of the last write sets `done` and pulses `irq` high for one cycle. `done` stays 1 until `done_clr` is pulsed or a new run is started.
- R9: A `sw_start` pulse while `busy` is 1 has no effect on the run in progress: its count, pointers and configuration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 32 | Source start pointer |
| cfg_dst | input | 32 | Destination start pointer |
| cfg_size | input | 2 | Beat size: 0 byte, 1 half-word, 2 word |
| cfg_mode | input | 2 | Pacing: 0 block, 1 burst, 2 demand, 3 as burst |
| cfg_blk | input | 4 | Beats per block, 0 means 16 |
| cfg_xfer | input | 16 | Blocks per run, 0 means 65536 |
| cfg_src_hold | input | 1 | Keep source pointer fixed |
| cfg_dst_hold | input | 1 | Keep destination pointer fixed |
| sw_start | input | 1 | Software start pulse |
| periph_req | input | 1 | Peripheral request line |
| done_clr | input | 1 | Clears the completion flag |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Size of the access |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, right-justified, valid with grant |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions take the following for granted about the inputs:
- `mem_gnt` only means something while `mem_req` is high.
- The memory answers reads in the grant cycle.
- The configuration inputs matter only in the cycle of an accepted start.

The stimulus keeps within these assumptions. A behavioural byte memory raises grant only alongside a request, with a periodic stall, and returns data combinationally in that cycle. Requests and starts are driven on the falling edge, as single-cycle pulses or as held levels, depending on the mode under test. The configuration is changed mid-run only in the test that expects it to be ignored.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int XFER_DW = 32;

  typedef enum logic [1:0] {
    MODE_BLOCK  = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_SPARE  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } seq_state_e;

  function automatic logic [2:0] beat_step(xfer_size_e s);
    case (s)
      SZ_BYTE: beat_step = 3'd1;
      SZ_HALF: beat_step = 3'd2;
      default: beat_step = 3'd4;
    endcase
  endfunction

  function automatic logic [XFER_DW-1:0] lane_mask(xfer_size_e s);
    case (s)
      SZ_BYTE: lane_mask = {{(XFER_DW-8){1'b0}}, 8'hFF};
      SZ_HALF: lane_mask = {{(XFER_DW-16){1'b0}}, 16'hFFFF};
      default: lane_mask = {XFER_DW{1'b1}};
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          hold,
  input  xfer_size_e    size,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= base;
    end else if (advance && !hold) begin
      addr <= addr + AW'(beat_step(size));
    end
  end

  // R5: a held pointer never moves on a beat
  assert_fixed_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && hold && !load) |=> $stable(addr));

  // R5: a free pointer always moves on a beat
  assert_step_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && !hold && !load) |=> !$stable(addr));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int BLK_W  = 4,
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk_cfg,
  input  logic [XFER_W-1:0] xfer_cfg,
  input  logic              beat,
  output logic              blk_last,
  output logic              final_beat
);

  localparam int BLK_CW  = BLK_W + 1;
  localparam int XFER_CW = XFER_W + 1;

  logic [BLK_CW-1:0]  blk_full, blk_reload, blk_rem;
  logic [XFER_CW-1:0] xfer_full, xfer_rem;

  // zero encodes the largest count
  always_comb begin
    blk_full  = (blk_cfg == '0)  ? {1'b1, {BLK_W{1'b0}}}  : {1'b0, blk_cfg};
    xfer_full = (xfer_cfg == '0) ? {1'b1, {XFER_W{1'b0}}} : {1'b0, xfer_cfg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_rem    <= '0;
      blk_reload <= '0;
      xfer_rem   <= '0;
    end else if (load) begin
      blk_rem    <= blk_full;
      blk_reload <= blk_full;
      xfer_rem   <= xfer_full;
    end else if (beat) begin
      if (blk_rem == BLK_CW'(1)) begin
        blk_rem  <= blk_reload;
        xfer_rem <= xfer_rem - XFER_CW'(1);
      end else begin
        blk_rem <= blk_rem - BLK_CW'(1);
      end
    end
  end

  assign blk_last   = (blk_rem == BLK_CW'(1));
  assign final_beat = blk_last && (xfer_rem == XFER_CW'(1));

  // R6: no beat is ever counted against an empty counter
  assert_beat_live_R6: assert property (@(posedge clk) disable iff (rst)
    beat |-> (blk_rem != '0) && (xfer_rem != '0));

  // R6: the block counter never exceeds its reload value
  assert_blk_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (blk_rem <= blk_reload));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  xfer_mode_e mode,
  input  logic       req_lvl,
  input  logic       req_pend,
  input  logic       gnt,
  input  logic       blk_last,
  input  logic       final_beat,
  output seq_state_e state,
  output logic       arm,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic       finish,
  output logic       take_req
);

  seq_state_e nxt;

  assign arm      = (state == ST_IDLE) && start;
  assign rd_ok    = (state == ST_RD) && gnt;
  assign wr_ok    = (state == ST_WR) && gnt;
  assign finish   = wr_ok && final_beat;
  assign take_req = (state == ST_GATE) && (mode == MODE_BLOCK) && req_pend;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_GATE;
      ST_GATE: begin
        case (mode)
          MODE_BLOCK:  if (req_pend) nxt = ST_RD;
          MODE_DEMAND: if (req_lvl)  nxt = ST_RD;
          default:                   nxt = ST_RD;
        endcase
      end
      ST_RD: if (gnt) nxt = ST_WR;
      ST_WR: begin
        if (gnt) begin
          if (final_beat) begin
            nxt = ST_IDLE;
          end else begin
            case (mode)
              MODE_BLOCK:  nxt = blk_last ? ST_GATE : ST_RD;
              MODE_DEMAND: nxt = req_lvl  ? ST_RD   : ST_GATE;
              default:     nxt = ST_RD;
            endcase
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R3: without a pending request a block-mode channel does not start a read
  assert_block_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GATE && mode == MODE_BLOCK && !req_pend) |=> (state != ST_RD));

  // R2: burst mode chains beats with no gap
  assert_burst_chain_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && gnt && !final_beat && mode == MODE_BURST) |=> (state == ST_RD));

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dma_xfer_pkg::*;
#(
  parameter int AW     = 32,
  parameter int BLK_W  = 4,
  parameter int XFER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      cfg_src,
  input  logic [AW-1:0]      cfg_dst,
  input  logic [1:0]         cfg_size,
  input  logic [1:0]         cfg_mode,
  input  logic [BLK_W-1:0]   cfg_blk,
  input  logic [XFER_W-1:0]  cfg_xfer,
  input  logic               cfg_src_hold,
  input  logic               cfg_dst_hold,
  input  logic               sw_start,
  input  logic               periph_req,
  input  logic               done_clr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [1:0]         mem_size,
  output logic [XFER_DW-1:0] mem_wdata,
  input  logic               mem_gnt,
  input  logic [XFER_DW-1:0] mem_rdata,
  output logic               busy,
  output logic               done,
  output logic               irq
);

  seq_state_e         state;
  xfer_mode_e         mode_q;
  xfer_size_e         size_q;
  logic               src_hold_q, dst_hold_q;
  logic               arm, rd_ok, wr_ok, finish, take_req;
  logic               blk_last, final_beat;
  logic               req_q, req_rise, req_pend;
  logic [AW-1:0]      src_addr, dst_addr;
  logic [XFER_DW-1:0] data_q;

  // configuration is captured once per run
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_BLOCK;
      size_q     <= SZ_BYTE;
      src_hold_q <= 1'b0;
      dst_hold_q <= 1'b0;
    end else if (arm) begin
      mode_q     <= xfer_mode_e'(cfg_mode);
      size_q     <= xfer_size_e'(cfg_size);
      src_hold_q <= cfg_src_hold;
      dst_hold_q <= cfg_dst_hold;
    end
  end

  // request edge memory for block pacing
  assign req_rise = periph_req && !req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      req_pend <= 1'b0;
    end else begin
      req_q <= periph_req;
      if (arm || take_req) req_pend <= req_rise;
      else if (req_rise)   req_pend <= 1'b1;
    end
  end

  dma_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (sw_start),
    .mode       (mode_q),
    .req_lvl    (periph_req),
    .req_pend   (req_pend),
    .gnt        (mem_gnt),
    .blk_last   (blk_last),
    .final_beat (final_beat),
    .state      (state),
    .arm        (arm),
    .rd_ok      (rd_ok),
    .wr_ok      (wr_ok),
    .finish     (finish),
    .take_req   (take_req)
  );

  dma_count_unit #(.BLK_W(BLK_W), .XFER_W(XFER_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load       (arm),
    .blk_cfg    (cfg_blk),
    .xfer_cfg   (cfg_xfer),
    .beat       (wr_ok),
    .blk_last   (blk_last),
    .final_beat (final_beat)
  );

  dma_addr_gen #(.AW(AW)) u_src_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (arm),
    .base    (cfg_src),
    .advance (rd_ok),
    .hold    (src_hold_q),
    .size    (size_q),
    .addr    (src_addr)
  );

  dma_addr_gen #(.AW(AW)) u_dst_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (arm),
    .base    (cfg_dst),
    .advance (wr_ok),
    .hold    (dst_hold_q),
    .size    (size_q),
    .addr    (dst_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)        data_q <= '0;
    else if (rd_ok) data_q <= mem_rdata & lane_mask(size_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= finish;
      if (finish)        done <= 1'b1;
      else if (arm)      done <= 1'b0;
      else if (done_clr) done <= 1'b0;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_WR) ? dst_addr : src_addr;
  assign mem_size  = size_q;
  assign mem_wdata = data_q;

  // R7: a stalled access keeps address and direction
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: demand channel stays off the bus while the request line is low
  assert_demand_pause_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DEMAND && busy && !mem_req && !periph_req) |=> !mem_req);

  // R8: completion only follows an accepted write
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(mem_we && mem_gnt));

  // R8: the interrupt is a single-cycle pulse
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

endmodule

// File: tb/dma_xfer_channel_bench.sv
module dma_xfer_channel_bench;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  size;
    logic [3:0]  blk;
    logic [15:0] xfer;
    logic [9:0]  src;
    logic [9:0]  dst;
    logic        sfix;
    logic        dfix;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd0, 4'd4, 16'd3, 10'h010, 10'h200, 1'b0, 1'b0},
    '{2'd1, 2'd1, 4'd2, 16'd5, 10'h040, 10'h240, 1'b0, 1'b0},
    '{2'd1, 2'd2, 4'd0, 16'd1, 10'h080, 10'h280, 1'b0, 1'b0},
    '{2'd0, 2'd2, 4'd3, 16'd2, 10'h100, 10'h300, 1'b0, 1'b0},
    '{2'd2, 2'd1, 4'd5, 16'd2, 10'h140, 10'h340, 1'b0, 1'b0},
    '{2'd1, 2'd0, 4'd2, 16'd4, 10'h180, 10'h380, 1'b1, 1'b0},
    '{2'd1, 2'd2, 4'd1, 16'd6, 10'h1A0, 10'h3C0, 1'b0, 1'b1},
    '{2'd0, 2'd0, 4'd0, 16'd1, 10'h1C0, 10'h3E0, 1'b0, 1'b0},
    '{2'd3, 2'd2, 4'd2, 16'd2, 10'h020, 10'h220, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [1:0]  cfg_size = '0, cfg_mode = '0;
  logic [3:0]  cfg_blk = '0;
  logic [15:0] cfg_xfer = '0;
  logic        cfg_src_hold = 1'b0, cfg_dst_hold = 1'b0;
  logic        sw_start = 1'b0, periph_req = 1'b0, done_clr = 1'b0;
  logic        mem_req, mem_we, mem_gnt, busy, done, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  logic [7:0]  mem [0:1023];
  logic [1:0]  gcnt = '0;
  logic        fast = 1'b0;
  logic        mon_en = 1'b0;
  int          n_chk = 0, n_fail = 0;
  int          wr_cnt = 0, rd_cnt = 0, irq_cnt = 0, mon_err = 0;
  vec_t        cur;

  always #10 clk = ~clk;

  dma_xfer_channel u_dma_xfer_channel (
    .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_size(cfg_size), .cfg_mode(cfg_mode), .cfg_blk(cfg_blk),
    .cfg_xfer(cfg_xfer), .cfg_src_hold(cfg_src_hold), .cfg_dst_hold(cfg_dst_hold),
    .sw_start(sw_start), .periph_req(periph_req), .done_clr(done_clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .irq(irq)
  );

  // behavioural memory: stalls one cycle in four unless fast
  always @(posedge clk) gcnt <= gcnt + 2'd1;
  assign mem_gnt = mem_req && (fast || gcnt != 2'b11);

  logic [9:0] ra;
  assign ra = mem_addr[9:0];
  assign mem_rdata = {mem[ra + 10'd3], mem[ra + 10'd2], mem[ra + 10'd1], mem[ra]};

  function automatic int stp(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] pat(logic [9:0] a);
    return 8'(a * 13 + 5);
  endfunction

  function automatic logic [9:0] eaddr(logic [9:0] base, logic fix, logic [1:0] s, int k);
    return fix ? base : base + 10'(k * stp(s));
  endfunction

  function automatic logic [31:0] edata(logic [9:0] a, logic [1:0] s);
    logic [31:0] d = '0;
    for (int b = 0; b < stp(s); b++) d[8*b +: 8] = pat(a + 10'(b));
    return d;
  endfunction

  function automatic int nbeats(vec_t v);
    int b = (v.blk == 4'd0) ? 16 : int'(v.blk);
    int x = (v.xfer == 16'd0) ? 65536 : int'(v.xfer);
    return b * x;
  endfunction

  // bus monitor: writes memory and checks every beat (R5, R7)
  always @(negedge clk) begin
    if (!rst && mem_req && mem_gnt) begin
      if (mem_we) begin
        if (mon_en) begin
          if (mem_addr[9:0] != eaddr(cur.dst, cur.dfix, cur.size, wr_cnt)) mon_err++;
          if (mem_wdata != edata(eaddr(cur.src, cur.sfix, cur.size, wr_cnt), cur.size)) mon_err++;
          if (mem_size != cur.size) mon_err++;
        end
        for (int b = 0; b < stp(mem_size); b++) mem[ra + 10'(b)] = mem_wdata[8*b +: 8];
        wr_cnt++;
      end else begin
        if (mon_en && mem_addr[9:0] != eaddr(cur.src, cur.sfix, cur.size, rd_cnt)) mon_err++;
        rd_cnt++;
      end
    end
    if (irq) irq_cnt++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic fill_mem();
    for (int a = 0; a < 1024; a++) mem[a] = pat(10'(a));
  endtask

  task automatic apply_cfg(vec_t v);
    cur = v;
    cfg_src = {22'd0, v.src}; cfg_dst = {22'd0, v.dst};
    cfg_size = v.size; cfg_mode = v.mode; cfg_blk = v.blk; cfg_xfer = v.xfer;
    cfg_src_hold = v.sfix; cfg_dst_hold = v.dfix;
    wr_cnt = 0; rd_cnt = 0; irq_cnt = 0; mon_err = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  task automatic wait_writes(int n, int lim);
    for (int i = 0; i < lim && wr_cnt < n; i++) @(negedge clk);
  endtask

  task automatic check_mem(vec_t v, string tag);
    int bad = 0;
    int n = nbeats(v);
    for (int k = 0; k < n; k++) begin
      if (!v.dfix || k == n - 1) begin
        for (int b = 0; b < stp(v.size); b++)
          if (mem[eaddr(v.dst, v.dfix, v.size, k) + 10'(b)] !=
              pat(eaddr(v.src, v.sfix, v.size, k) + 10'(b))) bad++;
      end
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic run_vec(vec_t v);
    int n = nbeats(v);
    int bsz = (v.blk == 4'd0) ? 16 : int'(v.blk);
    int held;
    fill_mem();
    apply_cfg(v);
    mon_en = 1'b1;
    pulse_start();
    if (v.mode == 2'd0) begin
      for (int t = 0; t < int'(v.xfer); t++) begin
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
        wait_writes((t + 1) * bsz, 400);
        repeat (10) @(negedge clk);
        if (t == 0) check(wr_cnt == bsz, "R3 one block per request edge", wr_cnt, bsz);
        if (t == 0 && v.xfer > 1) check(busy && !mem_req, "R3 waits for next request", busy, 1);
      end
    end else if (v.mode == 2'd2) begin
      @(negedge clk); periph_req = 1'b1;
      wait_writes(2, 200);
      periph_req = 1'b0;
      repeat (12) @(negedge clk);
      held = wr_cnt;
      repeat (12) @(negedge clk);
      check(wr_cnt == held && !mem_req, "R4 paused while request low", wr_cnt, held);
      check(busy == 1'b1, "R4 still busy during pause", busy, 1);
      periph_req = 1'b1;
      wait_done(1000);
      @(negedge clk); periph_req = 1'b0;
    end
    wait_done(3000);
    check(done == 1'b1, "R8 done after run", done, 1);
    check(wr_cnt == n && rd_cnt == n, "R2 beat count", wr_cnt, n);
    repeat (2) @(negedge clk);
    check(irq_cnt == 1, "R8 single irq pulse", irq_cnt, 1);
    check(mon_err == 0, "R7 R5 beat address and data", mon_err, 0);
    check_mem(v, "R5 destination contents");
    mon_en = 1'b0;
    pulse_clr();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    vec_t v;
    fill_mem();
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq && !mem_req, "R1 reset state", {busy, done, irq, mem_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: done is sticky until cleared
    v = VECS[0];
    fill_mem(); apply_cfg(v); mon_en = 1'b1;
    pulse_start();
    wait_done(2000);
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R8 done holds", done, 1);
    pulse_clr();
    check(done == 1'b0, "R8 done_clr clears", done, 0);

    // R8: a new start clears a set flag
    fill_mem(); apply_cfg(v);
    pulse_start();
    wait_done(2000);
    repeat (3) @(negedge clk);
    fill_mem(); apply_cfg(v);
    pulse_start();
    check(done == 1'b0, "R8 start clears done", done, 0);
    wait_done(2000);
    pulse_clr();

    // R9: start while busy has no effect
    v = '{2'd1, 2'd0, 4'd4, 16'd4, 10'h010, 10'h200, 1'b0, 1'b0};
    fill_mem(); apply_cfg(v);
    pulse_start();
    wait_writes(3, 200);
    cfg_src = 32'h100; cfg_dst = 32'h300; cfg_size = 2'd2; cfg_mode = 2'd0;
    pulse_start();
    wait_done(2000);
    check(wr_cnt == 16, "R9 restart ignored count", wr_cnt, 16);
    check(mon_err == 0, "R9 restart ignored pointers", mon_err, 0);
    pulse_clr();

    // R1: reset in the middle of a run
    v = VECS[2];
    fill_mem(); apply_cfg(v);
    pulse_start();
    wait_writes(3, 200);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mem_req && !done, "R1 reset mid-run", {busy, mem_req, done}, 0);
    rst = 1'b0;
    mon_en = 1'b0;
    @(negedge clk);

    // R6: block count 0 with run count 0 is 16 x 65536? use 1 x 65536
    v = '{2'd1, 2'd2, 4'd1, 16'd0, 10'h040, 10'h240, 1'b1, 1'b1};
    fill_mem(); apply_cfg(v);
    fast = 1'b1;
    pulse_start();
    wait_done(140000);
    check(done == 1'b1, "R6 zero run count finishes", done, 1);
    check(wr_cnt == 65536, "R6 zero run count is 65536", wr_cnt, 65536);
    fast = 1'b0;

    summary();
    $finish;
  end

endmodule